// File: doc/BRIEF.md
# Subranging Converter Timing Sequencer

This block is the digital control side of a sampling converter that quantises each sample in four subranging steps. A rising edge on `start` samples the analog input: the track/hold is told to hold. A single step counter then fires one strobe for each of the four flash steps, in a fixed order. It pulses a latch-update strobe that loads the result word and the out-of-range flag into the output registers, and raises `dav` for a bounded number of clocks. When `dav` falls, the track/hold goes back to acquire mode and the sequencer can accept the next start.

The quantisers and subtraction DACs are outside this block. The corrected result word and the range flag arrive as digital inputs. They are captured only on the latch-update strobe, so the output word keeps the previous sample until the new one is ready. Every interval is a parameter counted in system clocks. The defaults (40 clocks to end of conversion, 10 clocks of `dav`, 8 clocks per step) give an 800 ns conversion at a 50 MHz clock.

Top module: `subrange_seq`

## Requirements
- R1: After reset, `hold`, `flash_stb`, `latch_upd`, `dav` and `busy` are low, and `data_out` and `range_flag` are zero.
- R2: In the idle state, a clock edge that sees `start` high after it was low on the previous edge begins a conversion: `hold` and `busy` are high from the next cycle on.
- R3: Each conversion fires exactly four one-cycle strobes in the order `flash_stb[0]` (first coarse), `[1]` (second coarse), `[2]` (back-end coarse), `[3]` (back-end fine). Strobe k is high in the cycle with index STEP_CLKS*(k+1)-1, where index 0 is the cycle right after the start edge.
- R4: `dav` rises CONV_CLKS cycles after the start edge, that is in the cycle with index CONV_CLKS.
- R5: `latch_upd` is high in cycle CONV_CLKS-3. At the edge that ends that cycle, `code_in` and `oor_in` are loaded into `data_out` and `range_flag`, which are then stable for two cycles before `dav` rises.
- R6: `dav` stays high for exactly DAV_CLKS cycles.
- R7: `hold` stays high from the start edge until `dav` falls, and it drops in the same cycle that `dav` drops.
- R8: `data_out` and `range_flag` keep the previous result in every cycle other than the one after `latch_upd`, including through the next conversion until its own latch update.
- R9: A rising edge on `start` while `busy` is high, including in the last cycle of `dav`, is ignored: the strobes, `dav` and `hold` keep the timing of the conversion already running.
- R10: `start` held high past the end of a conversion does not begin another one. Only a new low-to-high transition seen while idle does.
- R11: `busy` is high exactly while a conversion or its `dav` pulse is in progress, from the cycle after the start edge to the last `dav` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request; its rising edge samples the input |
| code_in | input | WIDTH | Corrected result word from the quantiser path |
| oor_in | input | 1 | Out-of-range indication from the quantiser path |
| hold | output | 1 | Track/hold control: 1 = hold, 0 = acquire |
| flash_stb | output | 4 | One-cycle strobes for the four quantisation steps |
| latch_upd | output | 1 | One-cycle strobe that loads the output registers |
| dav | output | 1 | Data-available pulse; its rising edge marks end of conversion |
| busy | output | 1 | High while a conversion or its dav pulse is running |
| data_out | output | WIDTH | Registered result word |
| range_flag | output | 1 | Registered out-of-range flag |

## Verification
The assertions check several properties on every cycle. Strobes are never simultaneous and always come in step order. `dav` is exactly DAV_CLKS cycles wide. `hold` covers `dav` and drops with it. The output registers change only after a latch update and are settled when `dav` rises. An accepted start leaves the block holding with no strobe. The exact cycle of each strobe, the 40-clock end-of-conversion time, the captured values and the rejection of start edges while busy or while `start` is held high are shown only by the bench's directed scenarios, which compare every cycle of a conversion against the expected timeline.

// File: rtl/subr_seq_pkg.sv
package subr_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_DAV  = 2'd2
  } seq_state_t;

  localparam int unsigned NUM_STEPS = 4;

  // Cycle index (counted from the start edge) at which step k strobes.
  function automatic int unsigned strobe_at(input int unsigned k, input int unsigned step_clks);
    return (k + 1) * step_clks - 1;
  endfunction

  // Cycle index of the latch-update strobe: two settled cycles before dav.
  function automatic int unsigned latch_at(input int unsigned conv_clks);
    return conv_clks - 3;
  endfunction

  // Counter width able to hold the larger of two counts.
  function automatic int unsigned count_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/start_edge.sv
module start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import subr_seq_pkg::*;
#(
  parameter int unsigned CONV_CLKS = 40,
  parameter int unsigned DAV_CLKS  = 10,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rise,
  output seq_state_t       state,
  output logic [CNT_W-1:0] cnt,
  output logic             conv_last,
  output logic             dav_last
);
  localparam logic [CNT_W-1:0] CONV_END = CNT_W'(CONV_CLKS - 1);
  localparam logic [CNT_W-1:0] DAV_END  = CNT_W'(DAV_CLKS - 1);

  assign conv_last = (state == ST_CONV) && (cnt == CONV_END);
  assign dav_last  = (state == ST_DAV)  && (cnt == DAV_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start_rise) state <= ST_CONV;
        end
        ST_CONV: begin
          if (conv_last) begin
            state <= ST_DAV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DAV: begin
          if (dav_last) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/step_strobes.sv
module step_strobes
  import subr_seq_pkg::*;
#(
  parameter int unsigned STEP_CLKS = 8,
  parameter int unsigned CONV_CLKS = 40,
  parameter int unsigned CNT_W     = 6
) (
  input  seq_state_t           state,
  input  logic [CNT_W-1:0]     cnt,
  output logic [NUM_STEPS-1:0] stb,
  output logic                 latch
);
  localparam logic [CNT_W-1:0] LATCH_IDX = CNT_W'(latch_at(CONV_CLKS));

  wire in_conv = (state == ST_CONV);

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
    localparam logic [CNT_W-1:0] STB_IDX = CNT_W'(strobe_at(k, STEP_CLKS));
    assign stb[k] = in_conv && (cnt == STB_IDX);
  end

  assign latch = in_conv && (cnt == LATCH_IDX);
endmodule

// File: rtl/result_reg.sv
module result_reg #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] code_in,
  input  logic             oor_in,
  output logic [WIDTH-1:0] data_q,
  output logic             oor_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oor_q  <= 1'b0;
    end else if (load) begin
      data_q <= code_in;
      oor_q  <= oor_in;
    end
  end
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
  import subr_seq_pkg::*;
#(
  parameter int unsigned WIDTH     = 12,
  parameter int unsigned STEP_CLKS = 8,
  parameter int unsigned CONV_CLKS = 40,
  parameter int unsigned DAV_CLKS  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] code_in,
  input  logic             oor_in,
  output logic             hold,
  output logic [3:0]       flash_stb,
  output logic             latch_upd,
  output logic             dav,
  output logic             busy,
  output logic [WIDTH-1:0] data_out,
  output logic             range_flag
);
  localparam int unsigned CNT_W = count_width(CONV_CLKS, DAV_CLKS);

  // Internal events, named for the checker.
  logic             start_rise;
  logic             conv_last;
  logic             dav_last;
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  start_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (start),
    .rise   (start_rise)
  );

  seq_ctrl #(
    .CONV_CLKS (CONV_CLKS),
    .DAV_CLKS  (DAV_CLKS),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_rise (start_rise),
    .state      (state),
    .cnt        (cnt),
    .conv_last  (conv_last),
    .dav_last   (dav_last)
  );

  step_strobes #(
    .STEP_CLKS (STEP_CLKS),
    .CONV_CLKS (CONV_CLKS),
    .CNT_W     (CNT_W)
  ) u_stb (
    .state (state),
    .cnt   (cnt),
    .stb   (flash_stb),
    .latch (latch_upd)
  );

  result_reg #(
    .WIDTH (WIDTH)
  ) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (latch_upd),
    .code_in (code_in),
    .oor_in  (oor_in),
    .data_q  (data_out),
    .oor_q   (range_flag)
  );

  assign busy = (state != ST_IDLE);
  assign hold = busy;
  assign dav  = (state == ST_DAV);
endmodule

// File: rtl/subrange_seq_chk.sv
module subrange_seq_chk #(
  parameter int unsigned WIDTH    = 12,
  parameter int unsigned DAV_CLKS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_rise,
  input logic             hold,
  input logic [3:0]       flash_stb,
  input logic             latch_upd,
  input logic             dav,
  input logic             busy,
  input logic [WIDTH-1:0] data_out,
  input logic             range_flag
);
  logic [15:0] dav_run;
  logic [1:0]  next_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav_run   <= '0;
      next_step <= '0;
    end else begin
      dav_run <= dav ? dav_run + 16'd1 : 16'd0;
      if (|flash_stb) next_step <= next_step + 2'd1;
    end
  end

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flash_stb));

  // R3
  strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flash_stb) |-> (flash_stb == (4'b0001 << next_step)));

  // R3
  strobe_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flash_stb) |-> (hold && !dav));

  // R6
  dav_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dav |-> (dav_run < 16'(DAV_CLKS)));

  // R6
  dav_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav) |-> (dav_run == 16'(DAV_CLKS)));

  // R7
  hold_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dav |-> hold);

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav) |-> !hold);

  // R5
  data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav) |-> ($stable(data_out) && $stable(range_flag) && !latch_upd));

  // R8
  data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(latch_upd) |-> ($stable(data_out) && $stable(range_flag)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !busy) |=> (hold && busy && !dav && (flash_stb == 4'b0000)));
endmodule

bind subrange_seq subrange_seq_chk #(
  .WIDTH    (WIDTH),
  .DAV_CLKS (DAV_CLKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_rise (start_rise),
  .hold       (hold),
  .flash_stb  (flash_stb),
  .latch_upd  (latch_upd),
  .dav        (dav),
  .busy       (busy),
  .data_out   (data_out),
  .range_flag (range_flag)
);

// File: tb/tb_subrange_seq.sv
module tb_subrange_seq;
  localparam int WIDTH = 12;
  localparam int STEP  = 8;
  localparam int CONV  = 40;
  localparam int DAVN  = 10;
  localparam int TAIL  = CONV + DAVN + 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] code_in = '0;
  logic             oor_in = 1'b0;
  logic             hold, latch_upd, dav, busy, range_flag;
  logic [3:0]       flash_stb;
  logic [WIDTH-1:0] data_out;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] prev_data = '0;
  logic             prev_oor  = 1'b0;

  always #5 clk = ~clk;

  subrange_seq #(
    .WIDTH (WIDTH), .STEP_CLKS (STEP), .CONV_CLKS (CONV), .DAV_CLKS (DAVN)
  ) dut (
    .clk (clk), .rst_n (rst_n), .start (start), .code_in (code_in), .oor_in (oor_in),
    .hold (hold), .flash_stb (flash_stb), .latch_upd (latch_upd), .dav (dav),
    .busy (busy), .data_out (data_out), .range_flag (range_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Checks the whole timeline of one conversion, cycle by cycle.
  // mode 0: clean pulse; 1: extra start edges while busy (R9); 2: start held high (R10).
  task automatic run_conv(input logic [WIDTH-1:0] code, input logic oor, input int mode);
    logic [3:0] exp_stb;
    logic       exp_dav, exp_hold, exp_latch;
    logic [WIDTH-1:0] exp_data;
    logic       exp_oor;
    code_in = code;
    oor_in  = oor;
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < TAIL; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) exp_stb[k] = (i == STEP * (k + 1) - 1);
      exp_latch = (i == CONV - 3);
      exp_dav   = (i >= CONV) && (i < CONV + DAVN);
      exp_hold  = (i < CONV + DAVN);
      exp_data  = (i >= CONV - 2) ? code : prev_data;
      exp_oor   = (i >= CONV - 2) ? oor : prev_oor;
      // R2 R3 R9: strobe pattern
      chk(flash_stb == exp_stb, $sformatf("R3/R9 strobes cycle %0d", i), 32'(flash_stb), 32'(exp_stb));
      // R5: latch strobe
      chk(latch_upd == exp_latch, $sformatf("R5 latch_upd cycle %0d", i), 32'(latch_upd), 32'(exp_latch));
      // R4 R6: dav timing
      chk(dav == exp_dav, $sformatf("R4/R6 dav cycle %0d", i), 32'(dav), 32'(exp_dav));
      // R2 R7: hold
      chk(hold == exp_hold, $sformatf("R2/R7 hold cycle %0d", i), 32'(hold), 32'(exp_hold));
      // R11: busy
      chk(busy == exp_hold, $sformatf("R11 busy cycle %0d", i), 32'(busy), 32'(exp_hold));
      // R5 R8: result registers
      chk(data_out == exp_data && range_flag == exp_oor, $sformatf("R5/R8 data cycle %0d", i),
          {19'd0, range_flag, data_out}, {19'd0, exp_oor, exp_data});
      if (i == CONV - 2) begin
        code_in = ~code;
        oor_in  = ~oor;
      end
      if (mode == 0 && i == 2) start = 1'b0;
      if (mode == 1) begin
        if (i == 2 || i == 22 || i == 46 || i == 52) start = 1'b0;
        if (i == 20 || i == 44 || i == CONV + DAVN - 1) start = 1'b1;
      end
    end
    prev_data = code;
    prev_oor  = oor;
  endtask

  task automatic t_reset;
    #1;
    // R1: values during and right after reset
    chk(!hold && !dav && !busy && !latch_upd && flash_stb == 4'b0, "R1 controls in reset",
        {27'd0, hold, dav, busy, latch_upd, |flash_stb}, 32'd0);
    chk(data_out == '0 && !range_flag, "R1 result in reset", 32'(data_out), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hold && !busy && !dav, "R1 idle after reset", {29'd0, hold, busy, dav}, 32'd0);
  endtask

  task automatic t_normal;
    run_conv(12'hA5C, 1'b0, 0);
    run_conv(12'hFFF, 1'b1, 0);
    run_conv(12'h000, 1'b1, 0);
  endtask

  task automatic t_ignore_busy;
    run_conv(12'h3C7, 1'b0, 1);
    // R9: late edge in last dav cycle left the block idle
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !hold, "R9 no restart from busy edge", {30'd0, busy, hold}, 32'd0);
    end
  endtask

  task automatic t_held_start;
    run_conv(12'h812, 1'b1, 2);
    // R10: start still high, no new conversion
    repeat (10) begin
      @(negedge clk);
      chk(!busy && flash_stb == 4'b0, "R10 held start does not restart", {31'd0, busy}, 32'd0);
    end
    start = 1'b0;
    @(negedge clk);
    // R10: fresh edge starts again
    run_conv(12'h1B4, 1'b0, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_ignore_busy();
    t_held_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule